// File: doc/BRIEF.md
# DMA Descriptor Locator and Fetcher

This block finds a channel's transfer descriptor in RAM and reads it in. Software loads a 32-bit table base pointer and, for each channel, picks whether the primary or the alternate descriptor is in use. When an arbiter grants a channel, the block works out the descriptor's word address. It then reads the three meaningful words of that entry over a plain valid/ready memory read port and hands the words to the transfer engine with a one-cycle done strobe.

The table holds a primary bank followed by an alternate bank. Each channel has one 16-byte entry in each bank. The alternate bank starts at 16 bytes times the channel count rounded up to a power of two. The whole table is twice that size, and the base pointer must be aligned to the table size. If a request arrives while the base is misaligned, the block raises an error strobe and issues no memory traffic.

Top module: `dsc_fetch_unit`

## Requirements
- R1: The base pointer register resets to 0 and takes `base_wr_data` on any cycle with `base_wr_en` high; the new value applies to requests accepted afterwards.
- R2: Each bit of `sel_q` resets to 0, where 0 selects the primary and 1 the alternate bank. A 1 in `sel_set` makes the bit 1 and a 1 in `sel_clr` makes it 0, both visible the next cycle. A 0 in either leaves the bit unchanged, and when a bit is set and cleared in the same cycle it ends at 0.
- R3: The entry address is base + (alternate ? 16·2^ceil(log2 NCH) : 0) + channel·16; with NCH=5 the alternate offset is 0x80.
- R4: An accepted fetch issues exactly three reads, in this order: entry+0 (source end pointer), entry+4 (destination end pointer), entry+8 (control word). The word at entry+12 is never read.
- R5: `mem_addr` and `mem_valid` stay constant until the cycle in which `mem_ready` is high. That cycle completes the read with `mem_rdata`, and the next read is presented on the following cycle.
- R6: `done` is high for exactly one cycle, the cycle after the control-word read completes. `desc_src`, `desc_dst` and `desc_ctl` then show the three words read and hold them until the next fetch overwrites them.
- R7: A request accepted while any of the low 5+ceil(log2 NCH) bits of the base are nonzero (bits [7:0] for NCH=5) drives `err` high for one cycle in the following cycle and issues no read.
- R8: `req_valid` is ignored while `busy` is high; a request during a fetch starts no reads and does not alter the fetch in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Load strobe for the table base pointer |
| base_wr_data | input | 32 | New table base pointer |
| sel_set | input | NCH | Per-channel: 1 selects the alternate bank |
| sel_clr | input | NCH | Per-channel: 1 selects the primary bank (wins over set) |
| sel_q | output | NCH | Current bank select bits |
| req_valid | input | 1 | Fetch request for the granted channel |
| req_chan | input | CW | Granted channel number, CW = max(1, ceil(log2 NCH)) |
| busy | output | 1 | A fetch is in progress |
| mem_valid | output | 1 | Read request valid |
| mem_addr | output | 32 | Read byte address |
| mem_ready | input | 1 | Read completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| done | output | 1 | One-cycle strobe: descriptor words are ready |
| desc_src | output | 32 | Source end pointer word |
| desc_dst | output | 32 | Destination end pointer word |
| desc_ctl | output | 32 | Control word |
| err | output | 1 | One-cycle strobe: request refused, base misaligned |

## Verification
The bench builds the block with NCH=5. This count is not a power of two, so it checks that the alternate offset rounds up to 0x80 and that the alignment check covers eight base bits rather than the bits the raw count would suggest. Five channels keep a sweep of every channel in both banks short. A memory model with rotating wait states makes every read see 0, 1 or 2 stall cycles.

// File: rtl/dsc_fetch_pkg.sv
package dsc_fetch_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_SRC  = 2'd1,
    FS_DST  = 2'd2,
    FS_CTL  = 2'd3
  } fetch_st_e;

  // log2 of the channel count rounded up to a power of two
  function automatic int unsigned f_bank_log(input int unsigned nch);
    return (nch > 1) ? $clog2(nch) : 0;
  endfunction

  // byte offset of the alternate bank
  function automatic logic [31:0] f_alt_offset(input int unsigned nch);
    return 32'd16 << f_bank_log(nch);
  endfunction

  // log2 of the full table size in bytes
  function automatic int unsigned f_table_log(input int unsigned nch);
    return 5 + f_bank_log(nch);
  endfunction

  function automatic logic f_misaligned(input logic [31:0] base, input int unsigned nch);
    logic [31:0] mask;
    mask = (32'd1 << f_table_log(nch)) - 32'd1;
    return (base & mask) != 32'd0;
  endfunction

  function automatic logic [31:0] f_entry_addr(input logic [31:0] base, input logic alt,
                                              input logic [31:0] chan, input int unsigned nch);
    return base + (alt ? f_alt_offset(nch) : 32'd0) + (chan << 4);
  endfunction

  // word offset inside an entry for each read phase
  function automatic logic [31:0] f_word_off(input fetch_st_e st);
    case (st)
      FS_DST:  return 32'd4;
      FS_CTL:  return 32'd8;
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/dsc_bank_sel.sv
module dsc_bank_sel #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sel_set,
  input  logic [NCH-1:0] sel_clr,
  output logic [NCH-1:0] sel_q
);

  logic [NCH-1:0] sel_next;

  always_comb begin
    sel_next = (sel_q | sel_set) & ~sel_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_next;
  end

  // R2: a cleared bit reads 0 next cycle, whatever the set input did
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel_clr) |=> ((sel_q & $past(sel_clr)) == '0));

  // R2: with no set or clear activity the bits hold
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_set == '0) && (sel_clr == '0)) |=> $stable(sel_q));

endmodule

// File: rtl/dsc_addr_gen.sv
module dsc_addr_gen
  import dsc_fetch_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic [31:0]    base,
  input  logic [CW-1:0]  chan,
  input  logic [NCH-1:0] sel_q,
  output logic [31:0]    entry_addr,
  output logic           misaligned
);

  logic        alt_pick;
  logic [31:0] chan_w;

  always_comb begin
    chan_w     = 32'(chan);
    alt_pick   = (chan_w < 32'(NCH)) ? sel_q[chan] : 1'b0;
    entry_addr = f_entry_addr(base, alt_pick, chan_w, NCH);
    misaligned = f_misaligned(base, NCH);
  end

  // R3: an entry computed from an aligned base always starts on 16 bytes
  always_comb begin
    if (!misaligned) a_r3_entry_on_16: assert (entry_addr[3:0] == 4'd0);
  end

endmodule

// File: rtl/dsc_fetch_seq.sv
module dsc_fetch_seq
  import dsc_fetch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        misaligned,
  input  logic [31:0] entry_addr,
  output logic        busy,
  output logic        mem_valid,
  output logic [31:0] mem_addr,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] desc_src,
  output logic [31:0] desc_dst,
  output logic [31:0] desc_ctl,
  output logic        err
);

  fetch_st_e   st_q;
  logic [31:0] base_q;
  logic        accept_ok;
  logic        accept_bad;
  logic        beat;

  assign accept_ok  = (st_q == FS_IDLE) && req_valid && !misaligned;
  assign accept_bad = (st_q == FS_IDLE) && req_valid &&  misaligned;
  assign beat       = mem_valid && mem_ready;

  assign busy      = (st_q != FS_IDLE);
  assign mem_valid = (st_q != FS_IDLE);
  assign mem_addr  = base_q + f_word_off(st_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= FS_IDLE;
      base_q   <= '0;
      desc_src <= '0;
      desc_dst <= '0;
      desc_ctl <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= accept_bad;
      case (st_q)
        FS_IDLE: if (accept_ok) begin
          base_q <= entry_addr;
          st_q   <= FS_SRC;
        end
        FS_SRC: if (beat) begin
          desc_src <= mem_rdata;
          st_q     <= FS_DST;
        end
        FS_DST: if (beat) begin
          desc_dst <= mem_rdata;
          st_q     <= FS_CTL;
        end
        FS_CTL: if (beat) begin
          desc_ctl <= mem_rdata;
          done     <= 1'b1;
          st_q     <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  // R5: a stalled read keeps its address and valid
  a_r5_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  // R4: the pad word of an entry is never requested
  a_r4_no_pad_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[3:0] != 4'hC));

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a refused request leaves the read port quiet
  a_r7_err_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_valid);

  // R8: while busy a request cannot restart the entry address
  a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat) |=> (busy && $stable(mem_addr)));

endmodule

// File: rtl/dsc_fetch_unit.sv
module dsc_fetch_unit
  import dsc_fetch_pkg::*;
#(
  parameter  int NCH = 8,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           base_wr_en,
  input  logic [31:0]    base_wr_data,
  input  logic [NCH-1:0] sel_set,
  input  logic [NCH-1:0] sel_clr,
  output logic [NCH-1:0] sel_q,
  input  logic           req_valid,
  input  logic [CW-1:0]  req_chan,
  output logic           busy,
  output logic           mem_valid,
  output logic [31:0]    mem_addr,
  input  logic           mem_ready,
  input  logic [31:0]    mem_rdata,
  output logic           done,
  output logic [31:0]    desc_src,
  output logic [31:0]    desc_dst,
  output logic [31:0]    desc_ctl,
  output logic           err
);

  logic [31:0] base_q;
  logic [31:0] entry_addr;
  logic        misaligned;

  always_ff @(posedge clk) begin
    if (!rst_n)          base_q <= '0;
    else if (base_wr_en) base_q <= base_wr_data;
  end

  dsc_bank_sel #(.NCH(NCH)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_set (sel_set),
    .sel_clr (sel_clr),
    .sel_q   (sel_q)
  );

  dsc_addr_gen #(.NCH(NCH), .CW(CW)) u_addr (
    .base       (base_q),
    .chan       (req_chan),
    .sel_q      (sel_q),
    .entry_addr (entry_addr),
    .misaligned (misaligned)
  );

  dsc_fetch_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .misaligned (misaligned),
    .entry_addr (entry_addr),
    .busy       (busy),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .desc_src   (desc_src),
    .desc_dst   (desc_dst),
    .desc_ctl   (desc_ctl),
    .err        (err)
  );

  // R7: err only follows a request made against a misaligned base
  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(req_valid) && $past(misaligned)));

  // R1: a base write lands in the register the next cycle
  a_r1_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_en |=> (base_q == $past(base_wr_data)));

endmodule

// File: tb/dsc_fetch_unit_test.sv
module dsc_fetch_unit_test;

  localparam int NCH = 5;
  localparam int CW  = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           base_wr_en = 1'b0;
  logic [31:0]    base_wr_data = '0;
  logic [NCH-1:0] sel_set = '0;
  logic [NCH-1:0] sel_clr = '0;
  logic [NCH-1:0] sel_q;
  logic           req_valid = 1'b0;
  logic [CW-1:0]  req_chan = '0;
  logic           busy;
  logic           mem_valid;
  logic [31:0]    mem_addr;
  logic           mem_ready = 1'b0;
  logic [31:0]    mem_rdata;
  logic           done;
  logic [31:0]    desc_src, desc_dst, desc_ctl;
  logic           err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dsc_fetch_unit #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .sel_set(sel_set), .sel_clr(sel_clr), .sel_q(sel_q),
    .req_valid(req_valid), .req_chan(req_chan), .busy(busy),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .done(done), .desc_src(desc_src), .desc_dst(desc_dst), .desc_ctl(desc_ctl), .err(err)
  );

  function automatic logic [31:0] mfun(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0F0F;
  endfunction

  assign mem_rdata = mfun(mem_addr);

  // memory model: rotating 0/1/2 wait cycles, logs the address of every completed read
  logic [31:0] alog [0:7];
  int nlog = 0;
  int wcnt = 0;
  int wpat = 0;
  bit got_done = 0;
  always @(negedge clk) begin
    if (done) got_done = 1;
    if (mem_valid) begin
      if (wcnt == 0) begin
        mem_ready = 1'b1;
        if (nlog < 8) alog[nlog] = mem_addr;
        nlog = nlog + 1;
        wpat = wpat + 1;
        wcnt = wpat % 3;
      end else begin
        mem_ready = 1'b0;
        wcnt = wcnt - 1;
      end
    end else begin
      mem_ready = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] base_m, input int ch, input bit alt, input bit poke);
    logic [31:0] ea;
    int t;
    ea = base_m + (alt ? 32'h80 : 32'h0) + 32'(ch) * 32'd16;
    nlog = 0;
    got_done = 0;
    @(negedge clk); req_valid = 1'b1; req_chan = CW'(ch);
    @(negedge clk); req_valid = 1'b0;
    if (poke) begin
      @(negedge clk); req_valid = 1'b1; req_chan = CW'((ch + 1) % NCH);
      @(negedge clk); req_valid = 1'b0;
    end
    t = 0;
    while (!got_done && t < 60) begin @(negedge clk); t++; end
    chk(got_done, "R6 done seen", 32'(got_done), 32'd1);
    @(negedge clk);
    chk(!done, "R6 done one cycle", 32'(done), 32'd0);
    chk(nlog == 3, poke ? "R8 read count" : "R4 read count", 32'(nlog), 32'd3);
    chk(alog[0] == ea,         "R3 source address",  alog[0], ea);
    chk(alog[1] == ea + 32'd4, "R4 dest address",    alog[1], ea + 32'd4);
    chk(alog[2] == ea + 32'd8, "R4 control address", alog[2], ea + 32'd8);
    chk(desc_src == mfun(ea),         "R6 source word",  desc_src, mfun(ea));
    chk(desc_dst == mfun(ea + 32'd4), "R6 dest word",    desc_dst, mfun(ea + 32'd4));
    chk(desc_ctl == mfun(ea + 32'd8), "R6 control word", desc_ctl, mfun(ea + 32'd8));
  endtask

  task automatic write_base(input logic [31:0] b);
    @(negedge clk); base_wr_en = 1'b1; base_wr_data = b;
    @(negedge clk); base_wr_en = 1'b0;
  endtask

  task automatic sel_op(input logic [NCH-1:0] s, input logic [NCH-1:0] c);
    @(negedge clk); sel_set = s; sel_clr = c;
    @(negedge clk); sel_set = '0; sel_clr = '0;
  endtask

  task automatic bad_req(input logic [31:0] b);
    write_base(b);
    nlog = 0;
    @(negedge clk); req_valid = 1'b1; req_chan = 3'd1;
    @(negedge clk); req_valid = 1'b0;
    chk(err == 1'b1, "R7 err raised", 32'(err), 32'd1);
    chk(!mem_valid, "R7 no read", 32'(mem_valid), 32'd0);
    @(negedge clk);
    chk(err == 1'b0, "R7 err one cycle", 32'(err), 32'd0);
    @(negedge clk);
    chk(nlog == 0 && !busy, "R7 no traffic", 32'(nlog), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_q == '0, "R2 reset select", 32'(sel_q), 32'd0);
    chk(!busy && !mem_valid && !done && !err, "R6 reset outputs",
        {28'd0, busy, mem_valid, done, err}, 32'd0);

    // R1: base resets to zero
    do_fetch(32'h0, 2, 1'b0, 1'b0);

    // R2: set / clear rules
    sel_op(5'b10101, 5'b00000);
    chk(sel_q == 5'b10101, "R2 set", 32'(sel_q), 32'h15);
    sel_op(5'b00000, 5'b00000);
    chk(sel_q == 5'b10101, "R2 zero writes hold", 32'(sel_q), 32'h15);
    sel_op(5'b00011, 5'b00010);
    chk(sel_q == 5'b10101, "R2 clear wins", 32'(sel_q), 32'h15);
    sel_op(5'b00000, 5'b11111);
    chk(sel_q == 5'b00000, "R2 clear all", 32'(sel_q), 32'h0);

    // R1/R3/R4/R5/R6: every channel in both banks
    write_base(32'h2000_0100);
    for (int bank = 0; bank < 2; bank++) begin
      if (bank == 1) sel_op(5'b11111, 5'b00000);
      else           sel_op(5'b00000, 5'b11111);
      for (int ch = 0; ch < NCH; ch++) do_fetch(32'h2000_0100, ch, bank[0], 1'b0);
    end

    // R3: mixed selects pick per channel
    sel_op(5'b00000, 5'b01010);
    for (int ch = 0; ch < NCH; ch++) do_fetch(32'h2000_0100, ch, (ch % 2) == 0, 1'b0);

    // R8: request during a fetch is ignored
    do_fetch(32'h2000_0100, 3, 1'b0, 1'b1);
    do_fetch(32'h2000_0100, 4, 1'b1, 1'b1);

    // R7: misaligned bases
    bad_req(32'h2000_0180);
    bad_req(32'h2000_0104);

    // R1: a new aligned base takes effect
    write_base(32'h0004_0000);
    do_fetch(32'h0004_0000, 0, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule